// File: doc/BRIEF.md
# Two's-Complement Floating-Point Normalizer

This block turns an unnormalized floating-point value into its normalized form. The exponent is a two's-complement integer of `EXP_W` bits, sign included. The mantissa is a two's-complement fraction of `MAN_W` bits, sign included, with the binary point just right of the sign bit. A normalized mantissa has a magnitude of at least one half and below one. For a two's-complement fraction, that is true exactly when the sign bit differs from the bit just below it.

A one-cycle `start` pulse loads a value. The block then shifts the mantissa left by one bit per clock and lowers the exponent by one for each shift, until the normalization test passes. It then pulses `done` and holds the result until the next value completes. A zero mantissa cannot be normalized. It comes out as canonical zero: mantissa 0 with the most negative exponent. If a further shift is needed while the exponent is already at its most negative value, the block reports underflow and returns the same canonical zero. Normalization only lowers the exponent, so the overflow flag is never raised.

Top module: `fp_normalizer`

## Requirements
- R1: After reset, `done`, `underflow` and `overflow` are 0, and `exp_out` and `man_out` are all zeros.
- R2: When `done` is 1, `underflow` is 0 and `man_out` is nonzero, `man_out[MAN_W-1]` differs from `man_out[MAN_W-2]`.
- R3: `overflow` stays 0 for every input.
- R4: A result without underflow equals the input mantissa shifted left by s bits with zero fill, and the input exponent minus s. Here s is the smallest count of shifts that meets the R2 condition.
- R5: `done` rises s+1 clock edges after the edge that samples `start`.
- R6: A zero mantissa gives `done` after one edge, with `man_out` = 0, `exp_out` = the most negative exponent (sign bit 1, other bits 0) and `underflow` = 0.
- R7: If a shift is needed while the working exponent equals the most negative exponent, the result is `underflow` = 1, `man_out` = 0 and `exp_out` = the most negative exponent. The test for a normalized mantissa takes priority over this test.
- R8: A mantissa of -0.5 (binary 1.1000…0) counts as unnormalized. It becomes -1.0 (1.0000…0) after one shift, with the exponent lowered by one.
- R9: An input that is already normalized comes out unchanged after one edge.
- R10: A `start` pulse that arrives while a value is in progress is ignored. The first value's result and timing are unaffected, and no extra `done` follows.
- R11: `done` lasts one cycle. `exp_out`, `man_out` and `underflow` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load strobe for a new value |
| exp_in | input | EXP_W | Two's-complement input exponent |
| man_in | input | MAN_W | Two's-complement input mantissa |
| exp_out | output | EXP_W | Normalized exponent |
| man_out | output | MAN_W | Normalized mantissa |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Exponent overflow flag |
| underflow | output | 1 | Exponent underflow flag |

## Verification
Two events can fall due in the same cycle: the mantissa becoming normalized and the exponent reaching its floor. The bench provokes this by choosing an input exponent exactly s above the most negative value, so the last shift lands on the floor. The expected result is a normal output with no underflow. An exponent one step lower must instead give underflow. Random cases draw the shift count and the exponent independently, so this boundary is also hit by chance. Each case is judged on the result and on the cycle in which `done` rises.

// File: rtl/fp_normalizer_pkg.sv
package fp_normalizer_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } norm_state_e;
endpackage

// File: rtl/fp_norm_detect.sv
// Classifies a two's-complement fraction: zero, or normalized (sign differs from top value bit).
module fp_norm_detect #(
    parameter int MAN_W = 12
) (
    input  logic [MAN_W-1:0] man,
    output logic             is_zero,
    output logic             is_norm
);
    localparam int SIGN_POS = MAN_W - 1;
    localparam int TOP_POS  = MAN_W - 2;

    always_comb begin
        is_zero = (man == '0);
        is_norm = man[SIGN_POS] ^ man[TOP_POS];
    end
endmodule

// File: rtl/fp_norm_step.sv
// One normalization step: shift the mantissa left, lower the exponent, flag the exponent floor.
module fp_norm_step #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 12
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    output logic [EXP_W-1:0] exp_o,
    output logic [MAN_W-1:0] man_o,
    output logic             at_floor
);
    localparam logic [EXP_W-1:0] EXP_FLOOR = {1'b1, {(EXP_W-1){1'b0}}};
    localparam logic [EXP_W-1:0] EXP_ONE   = {{(EXP_W-1){1'b0}}, 1'b1};

    always_comb begin
        man_o    = {man_i[MAN_W-2:0], 1'b0};
        exp_o    = exp_i - EXP_ONE;
        at_floor = (exp_i == EXP_FLOOR);
    end
endmodule

// File: rtl/fp_normalizer.sv
module fp_normalizer #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EXP_W-1:0] exp_in,
    input  logic [MAN_W-1:0] man_in,
    output logic [EXP_W-1:0] exp_out,
    output logic [MAN_W-1:0] man_out,
    output logic             done,
    output logic             overflow,
    output logic             underflow
);
    import fp_normalizer_pkg::*;

    localparam logic [EXP_W-1:0] EXP_FLOOR = {1'b1, {(EXP_W-1){1'b0}}};

    typedef struct packed {
        norm_state_e      state;
        logic [EXP_W-1:0] work_exp;
        logic [MAN_W-1:0] work_man;
        logic [EXP_W-1:0] res_exp;
        logic [MAN_W-1:0] res_man;
        logic             res_uf;
        logic             done;
    } norm_regs_t;

    norm_regs_t r_d, r_q;

    logic             man_zero, man_norm, exp_floor;
    logic [EXP_W-1:0] next_exp;
    logic [MAN_W-1:0] next_man;

    fp_norm_detect #(.MAN_W(MAN_W)) u_detect (
        .man     (r_q.work_man),
        .is_zero (man_zero),
        .is_norm (man_norm)
    );

    fp_norm_step #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_step (
        .exp_i    (r_q.work_exp),
        .man_i    (r_q.work_man),
        .exp_o    (next_exp),
        .man_o    (next_man),
        .at_floor (exp_floor)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.work_exp = exp_in;
                    r_d.work_man = man_in;
                    r_d.state    = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (man_zero) begin
                    r_d.res_exp = EXP_FLOOR;
                    r_d.res_man = '0;
                    r_d.res_uf  = 1'b0;
                    r_d.done    = 1'b1;
                    r_d.state   = ST_IDLE;
                end else if (man_norm) begin
                    r_d.res_exp = r_q.work_exp;
                    r_d.res_man = r_q.work_man;
                    r_d.res_uf  = 1'b0;
                    r_d.done    = 1'b1;
                    r_d.state   = ST_IDLE;
                end else if (exp_floor) begin
                    r_d.res_exp = EXP_FLOOR;
                    r_d.res_man = '0;
                    r_d.res_uf  = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.state   = ST_IDLE;
                end else begin
                    r_d.work_exp = next_exp;
                    r_d.work_man = next_man;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, work_exp: '0, work_man: '0,
                     res_exp: '0, res_man: '0, res_uf: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign exp_out   = r_q.res_exp;
    assign man_out   = r_q.res_man;
    assign underflow = r_q.res_uf;
    assign done      = r_q.done;
    assign overflow  = 1'b0;
endmodule

// File: rtl/fp_normalizer_chk.sv
module fp_normalizer_chk #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             underflow,
    input logic [EXP_W-1:0] exp_out,
    input logic [MAN_W-1:0] man_out
);
    localparam logic [EXP_W-1:0] EXP_FLOOR = {1'b1, {(EXP_W-1){1'b0}}};

    assert_result_normalized_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !underflow && man_out != '0) |-> (man_out[MAN_W-1] != man_out[MAN_W-2]));

    assert_zero_canonical_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !underflow && man_out == '0) |-> (exp_out == EXP_FLOOR));

    assert_underflow_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && underflow) |-> (man_out == '0 && exp_out == EXP_FLOOR));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(man_out) && $stable(exp_out) && $stable(underflow)));
endmodule

bind fp_normalizer fp_normalizer_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .underflow (underflow),
    .exp_out   (exp_out),
    .man_out   (man_out)
);

// File: tb/fp_normalizer_bench.sv
`timescale 1ns/1ps
module fp_normalizer_bench;
    localparam int EW = 6;
    localparam int MW = 12;
    localparam logic [EW-1:0] EMIN = {1'b1, {(EW-1){1'b0}}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [EW-1:0] exp_in = '0;
    logic [MW-1:0] man_in = '0;
    logic [EW-1:0] exp_out;
    logic [MW-1:0] man_out;
    logic          done, overflow, underflow;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fp_normalizer #(.EXP_W(EW), .MAN_W(MW)) u_fp_normalizer (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_in(exp_in), .man_in(man_in),
        .exp_out(exp_out), .man_out(man_out), .done(done),
        .overflow(overflow), .underflow(underflow));

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void ref_norm(input logic [EW-1:0] e, input logic [MW-1:0] m,
                                     output logic [EW-1:0] eo, output logic [MW-1:0] mo,
                                     output logic uf, output int lat);
        lat = 1;
        uf  = 1'b0;
        eo  = EMIN;
        mo  = '0;
        if (m == '0) return;
        while (m[MW-1] == m[MW-2]) begin
            if (e == EMIN) begin
                uf = 1'b1;
                return;
            end
            m = {m[MW-2:0], 1'b0};
            e = e - 1'b1;
            lat++;
        end
        eo = e;
        mo = m;
    endfunction

    // Runs one value; busy_start pulses a second start two cycles in (R10).
    task automatic run_case(input string req, input logic [EW-1:0] e, input logic [MW-1:0] m,
                            input bit busy_start);
        logic [EW-1:0] eo;
        logic [MW-1:0] mo;
        logic          uf;
        int            lat, cyc;
        ref_norm(e, m, eo, mo, uf, lat);
        @(negedge clk);
        start  = 1'b1;
        exp_in = e;
        man_in = m;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc   = 0;
        while (cyc < 100) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (busy_start && cyc == 2) begin
                start  = 1'b1;
                exp_in = ~e;
                man_in = 12'h7ff;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        start = 1'b0;
        check({req, " R5"}, "latency", cyc, lat);
        check({req, " R4"}, "exp_out", exp_out, eo);
        check({req, " R4"}, "man_out", man_out, mo);
        check({req, " R7"}, "underflow", underflow, uf);
        check({req, " R3"}, "overflow", overflow, 0);
        if (uf == 1'b0 && mo != '0)
            check({req, " R2"}, "normalized", man_out[MW-1] ^ man_out[MW-2], 1);
        @(negedge clk);
        check({req, " R11"}, "done pulse", done, 0);
        check({req, " R11"}, "man held", man_out, mo);
        if (busy_start) begin
            repeat (20) begin
                @(negedge clk);
                check("R10", "no extra done", done, 0);
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", "done", done, 0);
        check("R1", "exp_out", exp_out, 0);
        check("R1", "man_out", man_out, 0);
        check("R1", "underflow", underflow, 0);
        check("R1", "overflow", overflow, 0);
        rst_n = 1'b1;

        run_case("R6", 6'h05, 12'h000, 1'b0);
        run_case("R9", 6'h03, 12'h400, 1'b0);
        run_case("R9", 6'h1f, 12'h800, 1'b0);
        run_case("R8", 6'h02, 12'hc00, 1'b0);
        run_case("R4", 6'h00, 12'h001, 1'b0);
        run_case("R4", 6'h10, 12'hfff, 1'b0);
        run_case("R7", EMIN, 12'h100, 1'b0);
        run_case("R7", EMIN + 6'd2, 12'h100, 1'b0);
        run_case("R7", EMIN + 6'd1, 12'h100, 1'b0);
        run_case("R7", EMIN + 6'd3, 12'hff0, 1'b0);
        run_case("R10", 6'h04, 12'h001, 1'b1);
        run_case("R6", EMIN, 12'h000, 1'b0);

        for (int i = 0; i < 300; i++) begin
            logic [MW-1:0] m;
            logic [EW-1:0] e;
            int            sh;
            sh = $urandom_range(MW - 1, 0);
            m  = MW'($signed($urandom()) >>> (32 - MW + sh));
            e  = ($urandom_range(3, 0) == 0) ? EMIN + EW'($urandom_range(MW - 1, 0))
                                             : EW'($urandom());
            run_case("R4", e, m, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule